// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block times the clock line of an I2C master. It divides the peripheral clock by a power of two to make an internal tick. It then holds SCL low for a programmed number of ticks and released for another programmed number, alternating between the two. Before it counts a half-period, it waits until the filtered SCL input has reached the level being driven. A target that stretches the clock therefore pauses the generator, with no time limit. A short-glitch filter cleans the SCL input before the generator compares it.

The byte engine raises `xfer_en` for the length of a transfer. While it is low, SCL stays released and no strobes are issued. When it rises, the generator begins at the start of a low phase. Three single-cycle strobes mark where SCL falls, where it rises, and a sample point in the middle of the high phase. The byte engine uses them to shift data out and to sample it.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, `scl_out` is 1 (released), every strobe is 0 and the stored clock-select value is 0.
- R2: The stored clock-select value takes `sel_wdata` only on a cycle where `sel_wr` and `sel_unlock` are both 1. A write with `sel_unlock` at 0 leaves it unchanged.
- R3: When the line follows the drive at once, each low half-period lasts `4 + (low_count + K) * 2^sel` clock cycles. It is measured from the fall strobe to the rise strobe.
- R4: Under the same condition, each high half-period lasts `4 + (high_count + K) * 2^sel` cycles, measured from the rise strobe to the next fall strobe.
- R5: The overhead K is 4 when the stored clock-select value is 0, and 3 for any other value.
- R6: A count of 0 in either width input is treated as 1.
- R7: A high pulse on `scl_in` that lasts one clock cycle does not count as the line being released.
- R8: While `scl_in` is held low after SCL is released, no fall strobe is issued. Once the line goes high, the next fall comes `4 + (high_count + K) * 2^sel` cycles after the cycle in which it went high.
- R9: While `xfer_en` is 0, `scl_out` is 1 from the following cycle on and no strobe is issued. The first fall strobe comes one cycle after `xfer_en` is seen at 1.
- R10: `scl_fall` and `scl_rise` are single-cycle pulses, asserted in the first cycle in which `scl_out` is 0 and 1 respectively. At most one strobe is high in any cycle.
- R11: `scl_mid` pulses once per high phase, `4 + floor((high_count + K) / 2) * 2^sel` cycles after the rise strobe, when the line is not stretched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_en | input | 1 | Byte engine active; SCL runs while 1 |
| sel_wr | input | 1 | Clock-select write strobe |
| sel_unlock | input | 1 | Write-protect release, must be 1 in the same write |
| sel_wdata | input | SEL_W | New clock-select value (division by 2^value) |
| low_count | input | CNT_W | Low-phase width count |
| high_count | input | CNT_W | High-phase width count |
| scl_in | input | 1 | Sampled SCL line level |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| scl_fall | output | 1 | One-cycle strobe at SCL fall |
| scl_rise | output | 1 | One-cycle strobe at SCL release |
| scl_mid | output | 1 | One-cycle strobe at the mid-high sample point |

## Verification
The bench builds the block with the default widths: a 3-bit clock-select value and 5-bit counts. This puts the slowest case, division by 128 with a count of 31, within a short run. It also reaches both overhead values, the zero-count clamp and the largest count. An externally held low level and a single-cycle glitch are laid over the looped-back line to check that the stretch wait and the filter behave correctly.

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_en,
  input  logic             sel_wr,
  input  logic             sel_unlock,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic [CNT_W-1:0] low_count,
  input  logic [CNT_W-1:0] high_count,
  input  logic             scl_in,
  output logic             scl_out,
  output logic             scl_fall,
  output logic             scl_rise,
  output logic             scl_mid
);
  localparam int PW = (1 << SEL_W) - 1;
  localparam int LW = CNT_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_t;
  st_t st;

  logic [SEL_W-1:0] sel_q;
  logic [PW-1:0]    pre;
  logic [LW-1:0]    tcnt;
  logic             synced;
  logic             s1, s2, filt;

  logic [CNT_W-1:0] cnt_raw, cnt_eff;
  logic [LW-1:0]    len, half;
  logic [PW:0]      one_sh;
  logic [PW-1:0]    mask;
  logic             tick;

  assign cnt_raw = (st == S_HIGH) ? high_count : low_count;
  assign cnt_eff = (cnt_raw == '0) ? CNT_W'(1) : cnt_raw;
  assign len     = LW'(cnt_eff) + ((sel_q == '0) ? LW'(4) : LW'(3));
  assign half    = len >> 1;
  assign one_sh  = (PW+1)'(1) << sel_q;
  assign mask    = PW'(one_sh - 1'b1);
  assign tick    = (pre == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      filt <= 1'b1;
    end else begin
      s1 <= scl_in;
      s2 <= s1;
      if (s1 == s2) filt <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      st       <= S_IDLE;
      scl_out  <= 1'b1;
      scl_fall <= 1'b0;
      scl_rise <= 1'b0;
      scl_mid  <= 1'b0;
      synced   <= 1'b0;
      pre      <= '0;
      tcnt     <= '0;
    end else begin
      if (sel_wr && sel_unlock) sel_q <= sel_wdata;
      scl_fall <= 1'b0;
      scl_rise <= 1'b0;
      scl_mid  <= 1'b0;
      if (!xfer_en) begin
        st      <= S_IDLE;
        scl_out <= 1'b1;
        synced  <= 1'b0;
      end else if (st == S_IDLE) begin
        st       <= S_LOW;
        scl_out  <= 1'b0;
        scl_fall <= 1'b1;
        synced   <= 1'b0;
      end else if (!synced) begin
        if (filt == scl_out) begin
          synced <= 1'b1;
          pre    <= '0;
          tcnt   <= '0;
        end
      end else if (tick) begin
        pre <= '0;
        if (tcnt == len - 1'b1) begin
          synced <= 1'b0;
          if (st == S_LOW) begin
            st       <= S_HIGH;
            scl_out  <= 1'b1;
            scl_rise <= 1'b1;
          end else begin
            st       <= S_LOW;
            scl_out  <= 1'b0;
            scl_fall <= 1'b1;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
          if (st == S_HIGH && tcnt == half - 1'b1) scl_mid <= 1'b1;
        end
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  a_r2_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_wr && sel_unlock) |=> $stable(sel_q));
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> scl_out && !scl_fall && !scl_rise && !scl_mid);
  a_r10_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> !scl_out && $past(scl_out));
  a_r10_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> scl_out && !$past(scl_out));
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_fall, scl_rise, scl_mid}));
  a_r11_mid_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    scl_mid |-> scl_out && $stable(scl_out));
endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;
  logic clk = 0, rst_n = 0;
  logic xfer_en = 0, sel_wr = 0, sel_unlock = 0;
  logic [2:0] sel_wdata = 0;
  logic [4:0] low_count = 0, high_count = 0;
  logic stretch = 0, glitch = 0;
  logic scl_in, scl_out, scl_fall, scl_rise, scl_mid;
  int cyc = 0, checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_in = glitch ? 1'b1 : (scl_out & ~stretch);

  scl_rate_gen i_scl_rate_gen (
    .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .sel_wr(sel_wr),
    .sel_unlock(sel_unlock), .sel_wdata(sel_wdata), .low_count(low_count),
    .high_count(high_count), .scl_in(scl_in), .scl_out(scl_out),
    .scl_fall(scl_fall), .scl_rise(scl_rise), .scl_mid(scl_mid));

  localparam bit [12:0] VEC [0:5] = '{
    {3'd0, 5'd1,  5'd1},
    {3'd0, 5'd31, 5'd10},
    {3'd1, 5'd5,  5'd7},
    {3'd3, 5'd2,  5'd0},
    {3'd2, 5'd0,  5'd12},
    {3'd7, 5'd31, 5'd31}
  };

  function automatic int half_len(int sel, int c);
    int e = (c == 0) ? 1 : c;
    return e + ((sel == 0) ? 4 : 3);
  endfunction

  function automatic int half_cyc(int sel, int c);
    return 4 + (half_len(sel, c) << sel);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_strobe(int which, output int t);
    bit seen = 0;
    t = -1;
    for (int n = 0; n < 20000 && !seen; n++) begin
      @(negedge clk);
      if ((which == 0 && scl_fall) || (which == 1 && scl_rise) ||
          (which == 2 && scl_mid)) begin
        seen = 1;
        t = cyc;
      end
    end
    if (!seen) begin
      checks++;
      errors++;
      $display("FAIL watchdog strobe %0d actual timeout expected pulse", which);
    end
  endtask

  task automatic write_sel(int v, bit unlock);
    @(negedge clk);
    sel_wdata = 3'(v); sel_wr = 1; sel_unlock = unlock;
    @(negedge clk);
    sel_wr = 0; sel_unlock = 0;
  endtask

  task automatic stop_run();
    @(negedge clk);
    xfer_en = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int t0, t1, tm, t2, sel, lo, hi, x, any;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 scl_out", scl_out, 1);
    chk("R1 strobes", {scl_fall, scl_rise, scl_mid}, 0);

    // R3 R4 R5 R6 R11: vector walk
    for (int i = 0; i < 6; i++) begin
      sel = VEC[i][12:10]; lo = VEC[i][9:5]; hi = VEC[i][4:0];
      write_sel(sel, 1);
      low_count = 5'(lo); high_count = 5'(hi);
      xfer_en = 1;
      wait_strobe(0, t0);
      wait_strobe(1, t1);
      wait_strobe(2, tm);
      wait_strobe(0, t2);
      chk("R3 R5 R6 low half", t1 - t0, half_cyc(sel, lo));
      chk("R4 R5 R6 high half", t2 - t1, half_cyc(sel, hi));
      chk("R11 mid point", tm - t1, 4 + ((half_len(sel, hi) / 2) << sel));
      stop_run();
    end

    // R1: select value after reset is 0 -> overhead 4 at division 1
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    low_count = 1; high_count = 1;
    xfer_en = 1;
    wait_strobe(0, t0);
    wait_strobe(1, t1);
    chk("R1 select reset to 0", t1 - t0, 9);
    stop_run();

    // R2: locked write ignored, unlocked write taken
    write_sel(5, 0);
    xfer_en = 1;
    wait_strobe(0, t0);
    wait_strobe(1, t1);
    chk("R2 locked write ignored", t1 - t0, 9);
    stop_run();
    write_sel(1, 1);
    xfer_en = 1;
    wait_strobe(0, t0);
    wait_strobe(1, t1);
    chk("R2 unlocked write", t1 - t0, 12);
    stop_run();

    // R9: start latency and idle release
    write_sel(0, 1);
    low_count = 2; high_count = 3;
    @(negedge clk);
    x = cyc;
    xfer_en = 1;
    wait_strobe(0, t0);
    chk("R9 start latency", t0 - x, 1);
    @(negedge clk);
    chk("R10 fall single cycle", scl_fall, 0);
    chk("R10 drive low after fall", scl_out, 0);
    xfer_en = 0;
    any = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (!scl_out || scl_fall || scl_rise || scl_mid) any = 1;
    end
    chk("R9 idle released no strobes", any, 0);

    // R8 R7: clock stretching with a single-cycle glitch
    xfer_en = 1;
    wait_strobe(0, t0);
    wait_strobe(1, t1);
    stretch = 1;
    any = 0;
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      if (scl_fall || !scl_out) any = 1;
    end
    chk("R8 held while stretched", any, 0);
    glitch = 1;
    @(negedge clk);
    glitch = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (scl_fall || scl_mid) any = 1;
    end
    chk("R7 glitch filtered", any, 0);
    x = cyc;
    stretch = 0;
    wait_strobe(0, t2);
    chk("R8 resume after release", t2 - x, half_cyc(0, 3));
    stop_run();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule